// File: doc/BRIEF.md
# DDR2 Read Burst Sequencer

This block is the read-return path of a DDR2-style memory device, modelled per clock cycle. It samples four active-low command pins on every rising edge and accepts a READ. The address bus at that edge gives the first column of the burst. Read latency is the sum of two mode fields, an additive part and a CAS part. Once it has elapsed, the block drives a strobe preamble and returns 4 or 8 beats from a small read-only storage array.

Double-rate output is shown as two words per clock: one for the first (strobe-high) half and one for the second (strobe-low) half. Separate enables cover data and the two strobe halves. Commands can be issued back to back, half a burst length apart, and the bursts come out with no gap between them. The mode fields are captured when a command is accepted, so a burst already in flight is not affected when they change later.

Top module: `rd_burst_seq`

## Requirements
- R1: A READ is accepted at a rising edge when cs_ni=0, ras_ni=1, cas_ni=0 and we_ni=1. Every other pin combination is ignored, and the outputs stay idle.
- R2: Read latency RL = al_i + cl_i. cl_i codes 0 and 1 are treated as 2. With the command taken at edge e, the first data cycle is the cycle that follows edge e+RL (for example AL=2, CL=3 gives edge e+5).
- R3: In the cycle before the first data cycle (the preamble), both strobe enables are 1, dqs_hi_o=0 and dq_oe_o=0.
- R4: A data cycle has dq_oe_o=1, both strobe enables at 1 and dqs_hi_o=1. dq_rise_o carries the even beat of the pair and dq_fall_o the odd beat.
- R5: bl8_i=1 selects an 8-beat burst (4 data cycles). bl8_i=0 selects 4 beats (2 data cycles).
- R6: Beat k reads column {start[5:3], (start[2:0]+k) mod BL} for BL=8, and {start[5:2], (start[1:0]+k) mod 4} for BL=4. This is sequential order, wrapping within the aligned block.
- R7: The stored word at column c is {~c, c}, with c zero-extended to 8 bits (16-bit data, 6-bit columns).
- R8: The cycle after the last data cycle is the postamble: dqs_oe_rise_o=1, dqs_hi_o=0, dqs_oe_fall_o=0 and dq_oe_o=0. After it, all enables return to 0.
- R9: READs spaced BL/2 cycles apart with equal modes give contiguous data cycles, with no preamble or postamble between the bursts.
- R10: READs spaced BL/2+1 cycles apart leave one cycle where a postamble and a preamble coincide. That cycle is driven as a full preamble.
- R11: When no burst is pending, all enables are 0 and both data words are 0.
- R12: AL, CL and burst length are captured at acceptance. Changing them afterwards leaves that burst's timing and length unchanged.
- R13: Under reset (rst_ni=0), all enables are 0 and both data words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe pin, active low |
| cas_ni | input | 1 | Column strobe pin, active low |
| we_ni | input | 1 | Write enable pin, active low |
| addr_i | input | COL_W | Starting column, sampled with READ |
| al_i | input | LAT_W | Additive latency field |
| cl_i | input | LAT_W | CAS latency field |
| bl8_i | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| dq_rise_o | output | DQ_W | Data word, first half of cycle |
| dq_fall_o | output | DQ_W | Data word, second half of cycle |
| dq_oe_o | output | 1 | Data output enable |
| dqs_hi_o | output | 1 | Strobe level in first half (second half is always low) |
| dqs_oe_rise_o | output | 1 | Strobe enable, first half |
| dqs_oe_fall_o | output | 1 | Strobe enable, second half |

## Verification
The bench targets the latency extremes (CL codes below 2, and AL=7 with CL=7). A design that adds wrongly or forgets the clamp shifts the whole burst and misses the preamble cycle. Start columns near the end of an aligned block test the wrap: an adder that carries into the upper column bits returns words from the neighbouring block. Reads spaced exactly half a burst apart must not show a preamble cycle between the bursts, and a spacing one cycle wider must merge the postamble and preamble into a full preamble rather than dropping one of them. Changing the mode fields right after a READ exposes a design that reads the live fields instead of the captured ones, because that burst then arrives at the wrong cycle.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

  // ordered so that the larger code wins when two bursts touch one cycle
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_POST = 2'd1,
    SLOT_PRE  = 2'd2,
    SLOT_DATA = 2'd3
  } slot_kind_e;

  function automatic logic is_read(input logic cs_n, input logic ras_n,
                                   input logic cas_n, input logic we_n);
    return !cs_n && ras_n && !cas_n && we_n;
  endfunction

endpackage

// File: rtl/rdseq_cmd_dec.sv
module rdseq_cmd_dec
  import rdseq_pkg::*;
#(
  parameter int COL_W = 6,
  parameter int LAT_W = 3,
  parameter int DEPTH = 18
) (
  input  logic             cs_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic [COL_W-1:0] addr_i,
  input  logic [LAT_W-1:0] al_i,
  input  logic [LAT_W-1:0] cl_i,
  input  logic             bl8_i,
  output slot_kind_e       inj_kind_o [DEPTH],
  output logic [COL_W-1:0] inj_rcol_o [DEPTH],
  output logic [COL_W-1:0] inj_fcol_o [DEPTH]
);
  localparam int CNT_W = $clog2(DEPTH + 2) + 1;
  localparam int BW    = 3;

  logic             rd_hit;
  logic [LAT_W-1:0] cl_eff;
  logic [CNT_W-1:0] rl_x;
  logic [CNT_W-1:0] half_x;
  logic [BW-1:0]    wrap_mask;
  logic [BW-1:0]    start_lo;

  always_comb begin
    rd_hit    = is_read(cs_ni, ras_ni, cas_ni, we_ni);
    cl_eff    = (cl_i < LAT_W'(2)) ? LAT_W'(2) : cl_i;
    rl_x      = CNT_W'(al_i) + CNT_W'(cl_eff);
    half_x    = bl8_i ? CNT_W'(4) : CNT_W'(2);
    wrap_mask = bl8_i ? 3'b111 : 3'b011;
    start_lo  = addr_i[BW-1:0];
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    localparam logic [CNT_W-1:0] CYC = CNT_W'(j + 1);
    logic [CNT_W-1:0] idx;
    logic [BW-1:0]    beat_r, beat_f, lo_r, lo_f;

    always_comb begin
      idx    = CYC - rl_x;
      beat_r = {idx[1:0], 1'b0};
      beat_f = {idx[1:0], 1'b1};
      lo_r   = (start_lo & ~wrap_mask) | ((start_lo + beat_r) & wrap_mask);
      lo_f   = (start_lo & ~wrap_mask) | ((start_lo + beat_f) & wrap_mask);
      inj_rcol_o[j] = {addr_i[COL_W-1:BW], lo_r};
      inj_fcol_o[j] = {addr_i[COL_W-1:BW], lo_f};
      if (!rd_hit)                                   inj_kind_o[j] = SLOT_IDLE;
      else if (CYC + CNT_W'(1) == rl_x)              inj_kind_o[j] = SLOT_PRE;
      else if (CYC >= rl_x && CYC < rl_x + half_x)   inj_kind_o[j] = SLOT_DATA;
      else if (CYC == rl_x + half_x)                 inj_kind_o[j] = SLOT_POST;
      else                                           inj_kind_o[j] = SLOT_IDLE;
    end
  end

endmodule

// File: rtl/rdseq_timeline.sv
module rdseq_timeline
  import rdseq_pkg::*;
#(
  parameter int COL_W = 6,
  parameter int DEPTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  slot_kind_e       inj_kind_i [DEPTH],
  input  logic [COL_W-1:0] inj_rcol_i [DEPTH],
  input  logic [COL_W-1:0] inj_fcol_i [DEPTH],
  output slot_kind_e       cur_kind_o,
  output logic [COL_W-1:0] cur_rcol_o,
  output logic [COL_W-1:0] cur_fcol_o
);
  // tl_kind_q[j] describes the cycle j+1 edges ahead
  slot_kind_e       tl_kind_q [DEPTH];
  logic [COL_W-1:0] tl_rcol_q [DEPTH];
  logic [COL_W-1:0] tl_fcol_q [DEPTH];

  slot_kind_e       nx_kind [DEPTH];
  logic [COL_W-1:0] nx_rcol [DEPTH];
  logic [COL_W-1:0] nx_fcol [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_merge
    slot_kind_e       old_kind;
    logic [COL_W-1:0] old_rcol, old_fcol;
    if (j == DEPTH - 1) begin : g_tail
      assign old_kind = SLOT_IDLE;
      assign old_rcol = '0;
      assign old_fcol = '0;
    end else begin : g_body
      assign old_kind = tl_kind_q[j+1];
      assign old_rcol = tl_rcol_q[j+1];
      assign old_fcol = tl_fcol_q[j+1];
    end
    always_comb begin
      if (inj_kind_i[j] > old_kind) begin
        nx_kind[j] = inj_kind_i[j];
        nx_rcol[j] = inj_rcol_i[j];
        nx_fcol[j] = inj_fcol_i[j];
      end else begin
        nx_kind[j] = old_kind;
        nx_rcol[j] = old_rcol;
        nx_fcol[j] = old_fcol;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_kind_o <= SLOT_IDLE;
      cur_rcol_o <= '0;
      cur_fcol_o <= '0;
      for (int j = 0; j < DEPTH; j++) begin
        tl_kind_q[j] <= SLOT_IDLE;
        tl_rcol_q[j] <= '0;
        tl_fcol_q[j] <= '0;
      end
    end else begin
      cur_kind_o <= tl_kind_q[0];
      cur_rcol_o <= tl_rcol_q[0];
      cur_fcol_o <= tl_fcol_q[0];
      for (int j = 0; j < DEPTH; j++) begin
        tl_kind_q[j] <= nx_kind[j];
        tl_rcol_q[j] <= nx_rcol[j];
        tl_fcol_q[j] <= nx_fcol[j];
      end
    end
  end

endmodule

// File: rtl/rdseq_store.sv
module rdseq_store #(
  parameter int COL_W = 6,
  parameter int DQ_W  = 16
) (
  input  logic [COL_W-1:0] rcol_i,
  input  logic [COL_W-1:0] fcol_i,
  output logic [DQ_W-1:0]  rword_o,
  output logic [DQ_W-1:0]  fword_o
);
  localparam int HALF  = DQ_W / 2;
  localparam int WORDS = 1 << COL_W;

  logic [DQ_W-1:0] rom [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    assign rom[i] = {~HALF'(i), HALF'(i)};
  end

  assign rword_o = rom[rcol_i];
  assign fword_o = rom[fcol_i];

endmodule

// File: rtl/rd_burst_seq.sv
module rd_burst_seq
  import rdseq_pkg::*;
#(
  parameter int COL_W = 6,
  parameter int DQ_W  = 16,
  parameter int LAT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic [COL_W-1:0] addr_i,
  input  logic [LAT_W-1:0] al_i,
  input  logic [LAT_W-1:0] cl_i,
  input  logic             bl8_i,
  output logic [DQ_W-1:0]  dq_rise_o,
  output logic [DQ_W-1:0]  dq_fall_o,
  output logic             dq_oe_o,
  output logic             dqs_hi_o,
  output logic             dqs_oe_rise_o,
  output logic             dqs_oe_fall_o
);
  localparam int MAX_RL = 2 * ((1 << LAT_W) - 1);
  localparam int DEPTH  = MAX_RL + 4;

  slot_kind_e       inj_kind [DEPTH];
  logic [COL_W-1:0] inj_rcol [DEPTH];
  logic [COL_W-1:0] inj_fcol [DEPTH];
  slot_kind_e       cur_kind;
  logic [COL_W-1:0] cur_rcol, cur_fcol;
  logic [DQ_W-1:0]  rword, fword;

  rdseq_cmd_dec #(.COL_W(COL_W), .LAT_W(LAT_W), .DEPTH(DEPTH)) u_dec (
    .cs_ni      (cs_ni),
    .ras_ni     (ras_ni),
    .cas_ni     (cas_ni),
    .we_ni      (we_ni),
    .addr_i     (addr_i),
    .al_i       (al_i),
    .cl_i       (cl_i),
    .bl8_i      (bl8_i),
    .inj_kind_o (inj_kind),
    .inj_rcol_o (inj_rcol),
    .inj_fcol_o (inj_fcol)
  );

  rdseq_timeline #(.COL_W(COL_W), .DEPTH(DEPTH)) u_tl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inj_kind_i (inj_kind),
    .inj_rcol_i (inj_rcol),
    .inj_fcol_i (inj_fcol),
    .cur_kind_o (cur_kind),
    .cur_rcol_o (cur_rcol),
    .cur_fcol_o (cur_fcol)
  );

  rdseq_store #(.COL_W(COL_W), .DQ_W(DQ_W)) u_store (
    .rcol_i  (cur_rcol),
    .fcol_i  (cur_fcol),
    .rword_o (rword),
    .fword_o (fword)
  );

  always_comb begin
    dq_oe_o       = (cur_kind == SLOT_DATA);
    dqs_hi_o      = (cur_kind == SLOT_DATA);
    dqs_oe_rise_o = (cur_kind != SLOT_IDLE);
    dqs_oe_fall_o = (cur_kind == SLOT_DATA) || (cur_kind == SLOT_PRE);
    dq_rise_o     = dq_oe_o ? rword : '0;
    dq_fall_o     = dq_oe_o ? fword : '0;
  end

endmodule

// File: rtl/rd_burst_seq_chk.sv
module rd_burst_seq_chk #(
  parameter int DQ_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [DQ_W-1:0] dq_rise_o,
  input logic [DQ_W-1:0] dq_fall_o,
  input logic            dq_oe_o,
  input logic            dqs_hi_o,
  input logic            dqs_oe_rise_o,
  input logic            dqs_oe_fall_o
);

  // R4
  data_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (dqs_oe_rise_o && dqs_oe_fall_o && dqs_hi_o));

  // R3
  preamble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> $past(dqs_oe_rise_o && dqs_oe_fall_o && !dqs_hi_o));

  // R8
  postamble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dq_oe_o) |-> (dqs_oe_rise_o && !dqs_hi_o));

  // R8
  fall_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqs_oe_fall_o |-> dqs_oe_rise_o);

  // R11
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> (dq_rise_o == '0 && dq_fall_o == '0 && !dqs_hi_o));

endmodule

bind rd_burst_seq rd_burst_seq_chk #(.DQ_W(DQ_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .dq_rise_o     (dq_rise_o),
  .dq_fall_o     (dq_fall_o),
  .dq_oe_o       (dq_oe_o),
  .dqs_hi_o      (dqs_hi_o),
  .dqs_oe_rise_o (dqs_oe_rise_o),
  .dqs_oe_fall_o (dqs_oe_fall_o)
);

// File: tb/sim_rd_burst_seq.sv
module sim_rd_burst_seq;
  localparam int MAXC = 8192;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b0, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [5:0]  addr_i = '0;
  logic [2:0]  al_i = '0, cl_i = 3'd3;
  logic        bl8_i = 1'b0;
  logic [15:0] dq_rise_o, dq_fall_o;
  logic        dq_oe_o, dqs_hi_o, dqs_oe_rise_o, dqs_oe_fall_o;

  int cyc = 0;
  int nvec = 0;
  int nfail = 0;
  int ek [MAXC];
  int erc [MAXC];
  int efc [MAXC];

  rd_burst_seq u0 (
    .clk_i, .rst_ni, .cs_ni, .ras_ni, .cas_ni, .we_ni, .addr_i,
    .al_i, .cl_i, .bl8_i, .dq_rise_o, .dq_fall_o, .dq_oe_o,
    .dqs_hi_o, .dqs_oe_rise_o, .dqs_oe_fall_o
  );

  always #10 clk_i = ~clk_i;  // 50 MHz
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int word_of(int c);
    return ((255 - c) << 8) | c;
  endfunction

  // expected slot codes: 0 idle, 1 postamble, 2 preamble, 3 data
  function automatic void model_read(int e, int a, int c, int b8, int col);
    int cq, rl, h, bl, base, off;
    cq = (c < 2) ? 2 : c;
    rl = a + cq;
    h = b8 ? 4 : 2;
    bl = 2 * h;
    off = col % bl;
    base = col - off;
    if (ek[e+rl-1] < 2) ek[e+rl-1] = 2;
    for (int i = 0; i < h; i++) begin
      if (ek[e+rl+i] < 3) begin
        ek[e+rl+i] = 3;
        erc[e+rl+i] = base + (off + 2*i) % bl;
        efc[e+rl+i] = base + (off + 2*i + 1) % bl;
      end
    end
    if (ek[e+rl+h] < 1) ek[e+rl+h] = 1;
  endfunction

  function automatic string kind_tag(int k);
    case (k)
      1: return "R8";
      2: return "R3";
      3: return "R4";
      default: return "R11";
    endcase
  endfunction

  task automatic compare(input string tag);
    int k;
    logic eoe, ehi, erise, efall;
    logic [15:0] er, ef;
    k = ek[cyc];
    eoe = (k == 3); ehi = (k == 3); erise = (k >= 1); efall = (k >= 2);
    er = (k == 3) ? 16'(word_of(erc[cyc])) : 16'h0;
    ef = (k == 3) ? 16'(word_of(efc[cyc])) : 16'h0;
    nvec++;
    if (dq_oe_o !== eoe || dqs_hi_o !== ehi || dqs_oe_rise_o !== erise ||
        dqs_oe_fall_o !== efall || dq_rise_o !== er || dq_fall_o !== ef) begin
      nfail++;
      $display("FAIL %s/%s cyc=%0d actual oe=%b hi=%b sr=%b sf=%b dr=%h df=%h expected oe=%b hi=%b sr=%b sf=%b dr=%h df=%h",
               tag, kind_tag(k), cyc, dq_oe_o, dqs_hi_o, dqs_oe_rise_o, dqs_oe_fall_o,
               dq_rise_o, dq_fall_o, eoe, ehi, erise, efall, er, ef);
    end
  endtask

  task automatic issue(input logic cs, ras, cas, we, input int col, input string tag);
    cs_ni = cs; ras_ni = ras; cas_ni = cas; we_ni = we; addr_i = 6'(col);
    if (!cs && ras && !cas && we)
      model_read(cyc + 1, int'(al_i), int'(cl_i), int'(bl8_i), col);
    @(negedge clk_i);
    compare(tag);
    cs_ni = 1'b0; ras_ni = 1'b1; cas_ni = 1'b1; we_ni = 1'b1;
  endtask

  task automatic rd(input int col, input string tag);
    issue(1'b0, 1'b1, 1'b0, 1'b1, col, tag);
  endtask

  task automatic nop(input int n, input string tag);
    for (int i = 0; i < n; i++) issue(1'b0, 1'b1, 1'b1, 1'b1, 0, tag);
  endtask

  task automatic mode(input int a, input int c, input int b8);
    al_i = 3'(a); cl_i = 3'(c); bl8_i = b8[0];
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    nfail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < MAXC; i++) begin ek[i] = 0; erc[i] = 0; efc[i] = 0; end
    // R13: outputs quiet while held in reset
    for (int i = 0; i < 3; i++) begin @(negedge clk_i); compare("R13"); end
    rst_ni = 1'b1;
    nop(2, "R13");

    // R1: non-READ pin patterns leave the outputs idle
    mode(0, 3, 0);
    issue(1'b0, 1'b0, 1'b1, 1'b1, 3, "R1");
    issue(1'b0, 1'b1, 1'b0, 1'b0, 3, "R1");
    issue(1'b0, 1'b0, 1'b1, 1'b0, 3, "R1");
    issue(1'b1, 1'b1, 1'b0, 1'b1, 3, "R1");
    issue(1'b0, 1'b0, 1'b0, 1'b1, 3, "R1");
    nop(12, "R1");

    // R2 + R6: AL=2 CL=3, BL4 from column 5 wraps 5,6,7,4
    mode(2, 3, 0); rd(5, "R6"); nop(12, "R6");
    // R5: BL8 from column 13 wraps inside 8..15
    mode(0, 3, 1); rd(13, "R5"); nop(14, "R5");
    // R2: largest latency and clamped CL code
    mode(7, 7, 1); rd(0, "R2"); nop(22, "R2");
    mode(0, 1, 0); rd(2, "R2"); nop(8, "R2");
    mode(0, 0, 1); rd(17, "R2"); nop(10, "R2");
    // R7: last and first columns
    mode(0, 2, 1); rd(63, "R7"); nop(6, "R7"); rd(0, "R7"); nop(10, "R7");

    // R9: gapless pipelining
    mode(1, 3, 0); rd(8, "R9"); nop(1, "R9"); rd(20, "R9"); nop(1, "R9"); rd(33, "R9"); nop(12, "R9");
    mode(0, 4, 1); rd(0, "R9"); nop(3, "R9"); rd(41, "R9"); nop(14, "R9");
    // R10: postamble meets preamble
    mode(1, 3, 0); rd(4, "R10"); nop(2, "R10"); rd(9, "R10"); nop(12, "R10");
    mode(2, 2, 1); rd(6, "R10"); nop(4, "R10"); rd(50, "R10"); nop(14, "R10");

    // R12: fields change right after acceptance
    mode(1, 4, 0); rd(6, "R12");
    mode(0, 2, 1); nop(14, "R12");
    mode(3, 5, 1); rd(30, "R12");
    mode(0, 0, 0); nop(18, "R12");

    // mixed traffic, fields changed only while idle
    for (int g = 0; g < 40; g++) begin
      int h;
      mode(int'($urandom % 8), int'($urandom % 8), int'($urandom % 2));
      h = bl8_i ? 4 : 2;
      for (int r = 0; r < 5; r++) begin
        int gap;
        rd(int'($urandom % 64), "R4");
        gap = h - 1 + int'($urandom % 3);
        for (int s = 0; s < gap; s++) begin
          logic [3:0] p;
          p = 4'($urandom);
          if (!p[3] && p[2] && !p[1] && p[0]) p = 4'b0111;
          issue(p[3], p[2], p[1], p[0], int'($urandom % 64), "R1");
        end
      end
      nop(20, "R11");
    end
    summary();
  end

endmodule